// File: doc/BRIEF.md
# Multi-Bus I/O Cycle Router

This block takes one processor I/O access (a read or a write of one, two or four bytes) and decides which device decode slot answers it. The slots are grouped into three tiers: board-level devices, expansion devices on a single-responder bus (PCI), and legacy devices on a shared bus with pull-ups (ISA). Each slot is a decoder outside this block. It looks at the current cycle's address and size and raises a claim line, and it offers read data. The router picks the answering tier. It merges conflicting legacy read data. It fans writes out to every claiming device of the handling tier. A wide access that nobody takes is broken into narrower pieces.

An accepted request is processed as a sequence of evaluation cycles, one per attempted access size and address. When no slot claims a wide piece, it is halved and retried at the same address. A piece that is claimed, or a single byte that is not, completes and places its bytes at their offset in the result. After the final piece, a one-cycle done pulse presents the assembled read data and the number of claims counted over the whole request.

Top module: `iocyc_router`

## Requirements
- R1: Slot bits are laid out per tier: bits [7:0] board tier, [15:8] PCI tier, [23:16] ISA tier (slot index = tier*8 + slot). The board tier is consulted only when address bits 15:8 are all zero. A board claim blocks both bus tiers, so neither gets a strobe or adds to the count. A board read returns the data of the lowest-numbered claiming board slot.
- R2: With the PCI bus enabled and no board claim, the lowest-numbered claiming PCI slot answers. It is the only PCI slot that is strobed or counted.
- R3: When a PCI slot answers, the ISA tier is still probed. Claiming ISA slots receive write strobes, their read data is discarded, and the count is one plus the number of ISA claims.
- R4: When the ISA tier answers a read, the returned data is the bitwise AND of the read data of every claiming ISA slot.
- R5: A write strobes every claiming slot of the tier that handles it, not just the first. A read never produces a strobe.
- R6: An unclaimed single-byte read returns 0xFF. An unclaimed single-byte write produces no strobe and adds nothing to the count.
- R7: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. An unclaimed piece wider than one byte is retried as two halves, lower address first, one evaluation per cycle. Each half is split again if still unclaimed. Bytes land at their offset from the request address (low byte at the lowest port), and write data is shifted to match.
- R8: With the PCI bus disabled, PCI claims are ignored and the ISA tier handles every access the board tier does not take.
- R9: A slot whose enable bit is low never counts as a claim and never receives a strobe.
- R10: The claim count sums the claims of all pieces of a request and saturates at 15.
- R11: resp_done is a one-cycle pulse in the cycle after the last evaluation. An unsplit access has exactly one evaluation. For writes resp_rdata is zero.
- R12: After reset resp_done, resp_rdata, resp_count, cyc_valid and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pci_bus_en | input | 1 | Enables the PCI tier |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | 16 | I/O port address |
| req_wdata | input | 32 | Write data, byte 0 for the lowest port |
| slot_en | input | 24 | Per-slot enable |
| slot_claim | input | 24 | Per-slot claim for the current cycle |
| slot_rdata | input | 768 | Per-slot read data, 32 bits each, slot 0 lowest |
| cyc_valid | output | 1 | An evaluation cycle is in progress |
| cyc_write | output | 1 | Direction of the current cycle |
| cyc_addr | output | 16 | Address of the current piece |
| cyc_size | output | 2 | Size code of the current piece |
| cyc_wdata | output | 32 | Write data of the current piece, low-aligned |
| slot_wstb | output | 24 | Per-slot write strobe |
| resp_done | output | 1 | Completion pulse |
| resp_rdata | output | 32 | Assembled read data |
| resp_count | output | 4 | Saturated claim count |

## Verification
The properties assume that every decoder derives its claim combinationally from cyc_addr and cyc_size within the same cycle. They also assume that pci_bus_en and the slot enables stay constant while a request is in flight, and that a new request is raised only after the previous done pulse. The bench keeps to this. Its device models are pure functions of the presented address and size, and every scenario task changes enables or the bus mode only between requests and waits for resp_done before returning.

// File: rtl/iocyc_pkg.sv
package iocyc_pkg;

   localparam int unsigned IO_DW = 32;
   localparam int unsigned IO_TIERS = 3;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // size code to byte count (code 3 behaves as 4 bytes)
   function automatic logic [2:0] code_to_bytes(input logic [1:0] code);
      case (code)
         2'd0:    code_to_bytes = 3'd1;
         2'd1:    code_to_bytes = 3'd2;
         default: code_to_bytes = 3'd4;
      endcase
   endfunction

   function automatic logic [1:0] bytes_to_code(input logic [2:0] nbytes);
      case (nbytes)
         3'd1:    bytes_to_code = 2'd0;
         3'd2:    bytes_to_code = 2'd1;
         default: bytes_to_code = 2'd2;
      endcase
   endfunction

   function automatic logic [IO_DW-1:0] lane_mask(input logic [2:0] nbytes);
      case (nbytes)
         3'd1:    lane_mask = 32'h0000_00FF;
         3'd2:    lane_mask = 32'h0000_FFFF;
         default: lane_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/iocyc_tier_scan.sv
module iocyc_tier_scan #(
   parameter int SLOTS = 8,
   parameter int DW    = 32
) (
   input  logic [SLOTS-1:0]            hit,
   input  logic [SLOTS*DW-1:0]         rdata,
   output logic                        any,
   output logic [SLOTS-1:0]            first_oh,
   output logic [DW-1:0]               first_data,
   output logic [DW-1:0]               and_data,
   output logic [$clog2(SLOTS+1)-1:0]  count
);
   localparam int PW = $clog2(SLOTS+1);

   always_comb begin
      first_oh   = '0;
      first_data = '0;
      and_data   = '1;
      count      = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (hit[i]) begin
            if (first_oh == '0) begin
               first_oh[i] = 1'b1;
               first_data  = rdata[i*DW +: DW];
            end
            and_data = and_data & rdata[i*DW +: DW];
            count    = count + PW'(1);
         end
      end
      any = |hit;
   end

endmodule

// File: rtl/iocyc_arbiter.sv
module iocyc_arbiter #(
   parameter int SLOTS  = 8,
   parameter int ADDR_W = 16,
   parameter int MB_LSB = 8,
   parameter int ACW    = 4
) (
   input  logic [ADDR_W-1:0]                       addr,
   input  logic                                    pci_on,
   input  logic [iocyc_pkg::IO_TIERS*SLOTS-1:0]    slot_claim,
   input  logic [iocyc_pkg::IO_TIERS*SLOTS-1:0]    slot_en,
   input  logic [iocyc_pkg::IO_TIERS*SLOTS*iocyc_pkg::IO_DW-1:0] slot_rdata,
   output logic                                    claimed,
   output logic [iocyc_pkg::IO_DW-1:0]             rdata,
   output logic [iocyc_pkg::IO_TIERS*SLOTS-1:0]    wsel,
   output logic [ACW-1:0]                          count
);
   import iocyc_pkg::*;

   localparam int PW = $clog2(SLOTS+1);
   localparam int TB = SLOTS * IO_DW;

   logic              mb_window;
   logic [SLOTS-1:0]  t_hit   [IO_TIERS];
   logic [SLOTS-1:0]  t_first [IO_TIERS];
   logic [IO_DW-1:0]  t_fdata [IO_TIERS];
   logic [IO_DW-1:0]  t_and   [IO_TIERS];
   logic              t_any   [IO_TIERS];
   logic [PW-1:0]     t_cnt   [IO_TIERS];

   assign mb_window = (addr[ADDR_W-1:MB_LSB] == '0);

   for (genvar t = 0; t < IO_TIERS; t++) begin : g_tier
      if (t == 0) begin : g_board
         assign t_hit[t] = slot_claim[t*SLOTS +: SLOTS] & slot_en[t*SLOTS +: SLOTS]
                           & {SLOTS{mb_window}};
      end else begin : g_bus
         assign t_hit[t] = slot_claim[t*SLOTS +: SLOTS] & slot_en[t*SLOTS +: SLOTS];
      end

      iocyc_tier_scan #(.SLOTS(SLOTS), .DW(IO_DW)) u_scan (
         .hit        (t_hit[t]),
         .rdata      (slot_rdata[t*TB +: TB]),
         .any        (t_any[t]),
         .first_oh   (t_first[t]),
         .first_data (t_fdata[t]),
         .and_data   (t_and[t]),
         .count      (t_cnt[t])
      );
   end

   always_comb begin
      claimed = 1'b0;
      rdata   = '0;
      wsel    = '0;
      count   = '0;
      if (t_any[0]) begin
         // board tier wins, bus tiers are not probed
         claimed              = 1'b1;
         rdata                = t_fdata[0];
         wsel[0 +: SLOTS]     = t_hit[0];
         count                = ACW'(t_cnt[0]);
      end else if (pci_on && t_any[1]) begin
         // single PCI responder; ISA still sees the cycle, its data dropped
         claimed              = 1'b1;
         rdata                = t_fdata[1];
         wsel[SLOTS +: SLOTS] = t_first[1];
         wsel[2*SLOTS +: SLOTS] = t_hit[2];
         count                = ACW'(1) + ACW'(t_cnt[2]);
      end else if (t_any[2]) begin
         // shared lines pulled up: conflicting drivers resolve as AND
         claimed              = 1'b1;
         rdata                = t_and[2];
         wsel[2*SLOTS +: SLOTS] = t_hit[2];
         count                = ACW'(t_cnt[2]);
      end
   end

endmodule

// File: rtl/iocyc_seq.sv
module iocyc_seq #(
   parameter int ADDR_W = 16,
   parameter int ACW    = 4,
   parameter int CNT_W  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic [1:0]                 req_size,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [iocyc_pkg::IO_DW-1:0] req_wdata,
   input  logic                       arb_claimed,
   input  logic [iocyc_pkg::IO_DW-1:0] arb_rdata,
   input  logic [ACW-1:0]             arb_count,
   output logic                       cyc_valid,
   output logic                       cyc_write,
   output logic [ADDR_W-1:0]          cyc_addr,
   output logic [1:0]                 cyc_size,
   output logic [iocyc_pkg::IO_DW-1:0] cyc_wdata,
   output logic                       resp_done,
   output logic [iocyc_pkg::IO_DW-1:0] resp_rdata,
   output logic [CNT_W-1:0]           resp_count
);
   import iocyc_pkg::*;

   localparam int SUMW = ((CNT_W > ACW) ? CNT_W : ACW) + 1;
   localparam logic [SUMW-1:0] CMAX = SUMW'((1 << CNT_W) - 1);

   seq_state_e          state_q;
   logic                wr_q;
   logic [ADDR_W-1:0]   base_q;
   logic [IO_DW-1:0]    wdata_q;
   logic [2:0]          total_q;
   logic [1:0]          off_q;
   logic [2:0]          csz_q;
   logic [IO_DW-1:0]    acc_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                done_q;
   logic [IO_DW-1:0]    rdata_q;
   logic [CNT_W-1:0]    rcnt_q;

   logic                piece_final;
   logic                last_piece;
   logic [IO_DW-1:0]    piece_data;
   logic [IO_DW-1:0]    placed;
   logic [2:0]          nxt_off;
   logic [2:0]          nxt_sz;
   logic [SUMW-1:0]     sum;
   logic [CNT_W-1:0]    cnt_sat;

   assign cyc_valid = (state_q == SEQ_RUN);
   assign cyc_write = wr_q;
   assign cyc_addr  = base_q + ADDR_W'(off_q);
   assign cyc_size  = bytes_to_code(csz_q);
   assign cyc_wdata = (wdata_q >> {off_q, 3'b000}) & lane_mask(csz_q);

   always_comb begin
      piece_final = arb_claimed || (csz_q == 3'd1);
      if (wr_q)             piece_data = '0;
      else if (arb_claimed) piece_data = arb_rdata & lane_mask(csz_q);
      else                  piece_data = 32'h0000_00FF;
      placed     = piece_data << {off_q, 3'b000};
      nxt_off    = {1'b0, off_q} + csz_q;
      last_piece = piece_final && (nxt_off == total_q);
      // next piece restarts at the widest size its offset alignment allows
      nxt_sz     = nxt_off[0] ? 3'd1 : (nxt_off[1] ? 3'd2 : 3'd4);
      sum        = SUMW'(cnt_q) + SUMW'(arb_count);
      cnt_sat    = (sum > CMAX) ? CMAX[CNT_W-1:0] : sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         wr_q    <= 1'b0;
         base_q  <= '0;
         wdata_q <= '0;
         total_q <= 3'd1;
         off_q   <= '0;
         csz_q   <= 3'd1;
         acc_q   <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         rdata_q <= '0;
         rcnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               if (req_valid) begin
                  state_q <= SEQ_RUN;
                  wr_q    <= req_write;
                  base_q  <= req_addr;
                  wdata_q <= req_wdata;
                  total_q <= code_to_bytes(req_size);
                  csz_q   <= code_to_bytes(req_size);
                  off_q   <= '0;
                  acc_q   <= '0;
                  cnt_q   <= '0;
               end
            end
            SEQ_RUN: begin
               cnt_q <= cnt_sat;
               if (piece_final) begin
                  acc_q <= acc_q | placed;
                  if (last_piece) begin
                     state_q <= SEQ_IDLE;
                     done_q  <= 1'b1;
                     rdata_q <= acc_q | placed;
                     rcnt_q  <= cnt_sat;
                  end else begin
                     off_q <= nxt_off[1:0];
                     csz_q <= nxt_sz;
                  end
               end else begin
                  csz_q <= csz_q >> 1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign resp_done  = done_q;
   assign resp_rdata = rdata_q;
   assign resp_count = rcnt_q;

endmodule

// File: rtl/iocyc_router.sv
module iocyc_router #(
   parameter int SLOTS  = 8,
   parameter int ADDR_W = 16,
   parameter int MB_LSB = 8,
   parameter int CNT_W  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pci_bus_en,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [1:0]                    req_size,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [31:0]                   req_wdata,
   input  logic [3*SLOTS-1:0]            slot_en,
   input  logic [3*SLOTS-1:0]            slot_claim,
   input  logic [3*SLOTS*32-1:0]         slot_rdata,
   output logic                          cyc_valid,
   output logic                          cyc_write,
   output logic [ADDR_W-1:0]             cyc_addr,
   output logic [1:0]                    cyc_size,
   output logic [31:0]                   cyc_wdata,
   output logic [3*SLOTS-1:0]            slot_wstb,
   output logic                          resp_done,
   output logic [31:0]                   resp_rdata,
   output logic [CNT_W-1:0]              resp_count
);
   localparam int ACW = $clog2(SLOTS+2);

   if (SLOTS < 1) begin : g_bad_slots
      $error("iocyc_router: SLOTS must be at least 1");
   end
   if (MB_LSB < 1 || MB_LSB >= ADDR_W) begin : g_bad_window
      $error("iocyc_router: MB_LSB must lie inside the address");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("iocyc_router: CNT_W must be at least 2");
   end

   logic              arb_claimed;
   logic [31:0]       arb_rdata;
   logic [3*SLOTS-1:0] arb_wsel;
   logic [ACW-1:0]    arb_count;

   iocyc_arbiter #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .MB_LSB(MB_LSB), .ACW(ACW)) u_arb (
      .addr       (cyc_addr),
      .pci_on     (pci_bus_en),
      .slot_claim (slot_claim),
      .slot_en    (slot_en),
      .slot_rdata (slot_rdata),
      .claimed    (arb_claimed),
      .rdata      (arb_rdata),
      .wsel       (arb_wsel),
      .count      (arb_count)
   );

   iocyc_seq #(.ADDR_W(ADDR_W), .ACW(ACW), .CNT_W(CNT_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_size    (req_size),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .arb_claimed (arb_claimed),
      .arb_rdata   (arb_rdata),
      .arb_count   (arb_count),
      .cyc_valid   (cyc_valid),
      .cyc_write   (cyc_write),
      .cyc_addr    (cyc_addr),
      .cyc_size    (cyc_size),
      .cyc_wdata   (cyc_wdata),
      .resp_done   (resp_done),
      .resp_rdata  (resp_rdata),
      .resp_count  (resp_count)
   );

   assign slot_wstb = (cyc_valid && cyc_write) ? arb_wsel : '0;

endmodule

// File: rtl/iocyc_router_chk.sv
module iocyc_router_chk #(
   parameter int SLOTS  = 8,
   parameter int ADDR_W = 16,
   parameter int MB_LSB = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pci_bus_en,
   input logic [3*SLOTS-1:0]   slot_en,
   input logic [3*SLOTS-1:0]   slot_claim,
   input logic                 cyc_valid,
   input logic                 cyc_write,
   input logic [ADDR_W-1:0]    cyc_addr,
   input logic [1:0]           cyc_size,
   input logic [3*SLOTS-1:0]   slot_wstb,
   input logic                 resp_done
);

   p_strobe_needs_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_wstb & ~(slot_claim & slot_en)) == '0);

   p_read_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && !cyc_write) |-> (slot_wstb == '0));

   p_board_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|slot_wstb[SLOTS-1:0]) |-> (cyc_addr[ADDR_W-1:MB_LSB] == '0));

   p_board_blocks_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|slot_wstb[SLOTS-1:0]) |-> (slot_wstb[3*SLOTS-1:SLOTS] == '0));

   p_one_pci_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_wstb[2*SLOTS-1:SLOTS]));

   p_pci_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pci_bus_en |-> (slot_wstb[2*SLOTS-1:SLOTS] == '0));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |=> !resp_done);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_valid |-> (slot_wstb == '0));

   p_split_halves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && $past(cyc_valid) && (cyc_addr == $past(cyc_addr))
       && (cyc_size != $past(cyc_size)))
      |-> (cyc_size == $past(cyc_size) - 2'd1));

endmodule

bind iocyc_router iocyc_router_chk #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .MB_LSB(MB_LSB)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pci_bus_en (pci_bus_en),
   .slot_en    (slot_en),
   .slot_claim (slot_claim),
   .cyc_valid  (cyc_valid),
   .cyc_write  (cyc_write),
   .cyc_addr   (cyc_addr),
   .cyc_size   (cyc_size),
   .slot_wstb  (slot_wstb),
   .resp_done  (resp_done)
);

// File: tb/iocyc_router_bench.sv
module iocyc_router_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pci_bus_en = 1'b1;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [1:0]        req_size = 2'd0;
   logic [15:0]       req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic [NS-1:0]     slot_en = '1;
   logic [NS-1:0]     slot_claim;
   logic [NS*32-1:0]  slot_rdata;
   logic              cyc_valid;
   logic              cyc_write;
   logic [15:0]       cyc_addr;
   logic [1:0]        cyc_size;
   logic [31:0]       cyc_wdata;
   logic [NS-1:0]     slot_wstb;
   logic              resp_done;
   logic [31:0]       resp_rdata;
   logic [3:0]        resp_count;

   logic [15:0] dev_lo  [NS];
   logic [15:0] dev_hi  [NS];
   logic [2:0]  dev_sz  [NS];
   logic [31:0] dev_val [NS];

   int total = 0;
   int bad = 0;

   int          n_ev;
   logic [15:0] ev_addr  [8];
   logic [1:0]  ev_size  [8];
   logic [NS-1:0] ev_wstb [8];
   logic [31:0] ev_wdata [8];
   logic [31:0] res_rdata;
   logic [3:0]  res_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   iocyc_router u_iocyc_router (
      .clk(clk), .rst_n(rst_n), .pci_bus_en(pci_bus_en),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .slot_en(slot_en), .slot_claim(slot_claim), .slot_rdata(slot_rdata),
      .cyc_valid(cyc_valid), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
      .cyc_size(cyc_size), .cyc_wdata(cyc_wdata), .slot_wstb(slot_wstb),
      .resp_done(resp_done), .resp_rdata(resp_rdata), .resp_count(resp_count)
   );

   // device decoders: pure functions of the presented address and size
   always_comb begin
      for (int i = 0; i < NS; i++) begin
         slot_claim[i] = (cyc_addr >= dev_lo[i]) && (cyc_addr <= dev_hi[i])
                         && dev_sz[i][cyc_size];
         slot_rdata[i*32 +: 32] = dev_val[i];
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_devs();
      for (int i = 0; i < NS; i++) begin
         dev_lo[i] = 16'hFFFF; dev_hi[i] = 16'h0000; dev_sz[i] = 3'b000; dev_val[i] = '0;
      end
      slot_en = '1;
   endtask

   task automatic set_dev(input int idx, input logic [15:0] lo, input logic [15:0] hi,
                          input logic [2:0] szm, input logic [31:0] val);
      dev_lo[idx] = lo; dev_hi[idx] = hi; dev_sz[idx] = szm; dev_val[idx] = val;
   endtask

   task automatic run_io(input logic wr, input logic [15:0] addr, input logic [1:0] sz,
                         input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n_ev = 0;
      for (int k = 0; k < 40; k++) begin
         if (resp_done) break;
         if (cyc_valid && n_ev < 8) begin
            ev_addr[n_ev] = cyc_addr; ev_size[n_ev] = cyc_size;
            ev_wstb[n_ev] = slot_wstb; ev_wdata[n_ev] = cyc_wdata;
            n_ev++;
         end
         @(negedge clk);
      end
      res_rdata = resp_rdata;
      res_count = resp_count;
   endtask

   task automatic t_reset();
      check("R12 done", 32'(resp_done), 0);
      check("R12 rdata", resp_rdata, 0);
      check("R12 count", 32'(resp_count), 0);
      check("R12 cyc_valid", 32'(cyc_valid), 0);
      check("R12 strobes", 32'(slot_wstb), 0);
   endtask

   task automatic t_board();
      clear_devs();
      set_dev(2, 16'h0060, 16'h0060, 3'b111, 32'h1122_3344);
      set_dev(5, 16'h0060, 16'h0060, 3'b111, 32'hAABB_CC77);
      set_dev(16, 16'h0060, 16'h0060, 3'b111, 32'h0);
      run_io(1'b0, 16'h0060, 2'd0, 0);
      check("R1 board read lowest slot", res_rdata, 32'h44);
      check("R1 board count", 32'(res_count), 2);
      check("R11 single evaluation", n_ev, 1);
      @(negedge clk);
      check("R11 done one cycle", 32'(resp_done), 0);
      run_io(1'b1, 16'h0060, 2'd0, 32'h5A);
      check("R5 board write strobes", 32'(ev_wstb[0]), 32'h000024);
      check("R1 write data", ev_wdata[0], 32'h5A);
      check("R11 write rdata zero", res_rdata, 0);
   endtask

   task automatic t_window();
      clear_devs();
      set_dev(1, 16'h0160, 16'h0160, 3'b111, 32'hDEAD_BEEF);
      set_dev(19, 16'h0160, 16'h0160, 3'b111, 32'h0000_00C1);
      run_io(1'b0, 16'h0160, 2'd0, 0);
      check("R1 outside board window", res_rdata, 32'hC1);
      check("R1 window count", 32'(res_count), 1);
      run_io(1'b1, 16'h0160, 2'd0, 32'h3);
      check("R1 window write strobe", 32'(ev_wstb[0]), 32'h080000);
   endtask

   task automatic t_pci();
      clear_devs();
      pci_bus_en = 1'b1;
      set_dev(9, 16'h0CF8, 16'h0CFB, 3'b111, 32'h1234_5678);
      set_dev(11, 16'h0CF8, 16'h0CFB, 3'b111, 32'h0);
      set_dev(16, 16'h0CF8, 16'h0CFB, 3'b111, 32'h0);
      run_io(1'b0, 16'h0CF8, 2'd1, 0);
      check("R2 pci first responder data", res_rdata, 32'h5678);
      check("R3 pci plus isa count", 32'(res_count), 2);
      run_io(1'b1, 16'h0CF8, 2'd1, 32'hBEEF);
      check("R3 pci and isa strobes", 32'(ev_wstb[0]), 32'h010200);
      check("R3 word write data", ev_wdata[0], 32'hBEEF);
   endtask

   task automatic t_isa_and();
      clear_devs();
      set_dev(16, 16'h0220, 16'h022F, 3'b111, 32'hF0);
      set_dev(20, 16'h0220, 16'h022F, 3'b111, 32'h3C);
      set_dev(23, 16'h0220, 16'h022F, 3'b111, 32'hAA);
      run_io(1'b0, 16'h0220, 2'd0, 0);
      check("R4 isa wired and", res_rdata, 32'h20);
      check("R4 isa count", 32'(res_count), 3);
      run_io(1'b1, 16'h0220, 2'd0, 32'h11);
      check("R5 isa all strobed", 32'(ev_wstb[0]), 32'h910000);
   endtask

   task automatic t_pci_off();
      clear_devs();
      pci_bus_en = 1'b0;
      set_dev(8, 16'h0300, 16'h0300, 3'b111, 32'h77);
      set_dev(18, 16'h0300, 16'h0300, 3'b111, 32'h99);
      run_io(1'b0, 16'h0300, 2'd0, 0);
      check("R8 isa only data", res_rdata, 32'h99);
      check("R8 isa only count", 32'(res_count), 1);
      run_io(1'b1, 16'h0300, 2'd0, 32'h1);
      check("R8 isa only strobe", 32'(ev_wstb[0]), 32'h040000);
      pci_bus_en = 1'b1;
   endtask

   task automatic t_disabled();
      clear_devs();
      set_dev(21, 16'h0330, 16'h0330, 3'b111, 32'h01);
      slot_en[21] = 1'b0;
      run_io(1'b0, 16'h0330, 2'd0, 0);
      check("R9 disabled slot read", res_rdata, 32'hFF);
      check("R6 unclaimed count", 32'(res_count), 0);
      run_io(1'b1, 16'h0330, 2'd0, 32'h42);
      check("R6 unclaimed write no strobe", 32'(ev_wstb[0]), 0);
      check("R9 disabled count", 32'(res_count), 0);
      slot_en = '1;
   endtask

   task automatic t_split2();
      clear_devs();
      set_dev(17, 16'h0340, 16'h0340, 3'b001, 32'h12);
      set_dev(22, 16'h0341, 16'h0341, 3'b001, 32'h34);
      run_io(1'b0, 16'h0340, 2'd1, 0);
      check("R7 word split data", res_rdata, 32'h3412);
      check("R7 word split evals", n_ev, 3);
      check("R7 second piece addr", 32'(ev_addr[2]), 32'h0341);
      check("R7 halved size", 32'(ev_size[1]), 0);
      check("R10 split count", 32'(res_count), 2);
   endtask

   task automatic t_split4();
      clear_devs();
      set_dev(16, 16'h0400, 16'h0400, 3'b010, 32'h0000_BEEF);
      set_dev(17, 16'h0402, 16'h0402, 3'b001, 32'h55);
      run_io(1'b0, 16'h0400, 2'd2, 0);
      check("R7 dword split data", res_rdata, 32'hFF55_BEEF);
      check("R7 dword split evals", n_ev, 5);
      check("R7 upper half addr", 32'(ev_addr[2]), 32'h0402);
      check("R7 upper half size", 32'(ev_size[2]), 1);
      check("R6 unclaimed byte in split", 32'(ev_addr[4]), 32'h0403);
   endtask

   task automatic t_split_write();
      logic [NS-1:0] others;
      clear_devs();
      set_dev(18, 16'h0501, 16'h0501, 3'b001, 32'h0);
      run_io(1'b1, 16'h0500, 2'd2, 32'hA1B2_C3D4);
      check("R7 write split evals", n_ev, 7);
      check("R7 byte piece strobe", 32'(ev_wstb[3]), 32'h040000);
      check("R7 byte piece data", ev_wdata[3], 32'hC3);
      check("R7 upper word data", ev_wdata[4], 32'hA1B2);
      others = '0;
      for (int k = 0; k < 7; k++) if (k != 3) others = others | ev_wstb[k];
      check("R6 no strobe on unclaimed pieces", 32'(others), 0);
      check("R11 write rdata zero", res_rdata, 0);
   endtask

   task automatic t_saturate();
      clear_devs();
      set_dev(8, 16'h0600, 16'h0603, 3'b010, 32'h0000_9876);
      for (int s = 16; s < 24; s++) set_dev(s, 16'h0600, 16'h0603, 3'b010, 32'hFFFF_FFFF);
      run_io(1'b0, 16'h0600, 2'd1, 0);
      check("R10 count below limit", 32'(res_count), 9);
      run_io(1'b0, 16'h0600, 2'd2, 0);
      check("R10 count saturates", 32'(res_count), 15);
      check("R3 pci data both halves", res_rdata, 32'h9876_9876);
      check("R7 claimed halves evals", n_ev, 3);
   endtask

   initial begin
      clear_devs();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_board();
      t_window();
      t_pci();
      t_isa_and();
      t_pci_off();
      t_disabled();
      t_split2();
      t_split4();
      t_split_write();
      t_saturate();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule